// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers 72 level-sensitive interrupt sources into one processor interrupt line. The sources fall into three groups: eight local sources and two 32-bit banks. Every source has an enable bit. Software never writes the enable masks directly. It writes ones to a set address or to a clear address for each group, and zero bits leave the mask unchanged. Pending state is the source level ANDed with its enable. It is never latched. A source stays pending until the device that raised it drops its level.

The local pending word gives a fast path for the interrupt handler. It holds the eight local sources. It also holds one summary flag per bank and copies of eleven frequently used bank sources. A handler can often find the cause from that single word, without reading a bank word.

One source can be chosen through a control register and sent to a separate fast-interrupt output. The chosen source is then taken out of the normal interrupt. Sources are numbered as one flat range:
- 0..7 are the local sources.
- 8..39 are bank A, numbered bank bit + 8.
- 40..71 are bank B, numbered bank bit + 40.

Top module: `irq_bank_ctrl`

## Requirements
- R1: During and after reset, all enable masks and the fast-interrupt control register are zero. Every mapped register reads zero, and `irq_o` and `fiq_o` are low.
- R2: A write to a set address ORs `wdata` into that group's enable mask, and zero bits have no effect. The set addresses are 0x10 for bank A, 0x14 for bank B and 0x18 for the local group, which uses only bits 7:0.
- R3: A write to a clear address removes the bits written as one from that group's mask. The clear addresses are 0x1C for bank A, 0x20 for bank B and 0x24 for the local group. Reading either the set address or the clear address of a group returns that group's current mask.
- R4: Address 0x04 reads bank A levels AND bank A mask. Address 0x08 reads the same for bank B.
- R5: Address 0x00 bits 7:0 read local levels AND local mask. Bits 31:21 of that word read zero.
- R6: Bit 8 of address 0x00 is set when any enabled bank A source is active, and bit 9 likewise for bank B. The eleven mirrored sources count toward these flags.
- R7: Bits 10..14 of address 0x00 mirror enabled bank A sources 7, 9, 10, 18 and 19, in that order. Bits 15..20 mirror enabled bank B sources 21, 22, 23, 24, 25 and 30, in that order.
- R8: `irq_o` goes high one clock after any enabled source is active, other than a source routed to `fiq_o`. It goes low one clock after none is. Reading a pending word changes no state.
- R9: Address 0x0C holds the fast-interrupt control: bits 6:0 are a flat source number and bit 7 is the enable. The register reads back in bits 7:0. While it is enabled, the selected source, when enabled and active, drives `fiq_o` one clock later and no longer contributes to `irq_o`.
- R10: A selected flat number of 72 or more routes nothing. `fiq_o` stays low and `irq_o` is unaffected.
- R11: `rdata` is valid the clock after `rd_en` and is zero in any cycle that follows no read. Unmapped or misaligned addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| src_local | input | 8 | Local source levels |
| src_bank_a | input | 32 | Bank A source levels |
| src_bank_b | input | 32 | Bank B source levels |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The local pending word is driven with one bank source at a time, both mirrored and unmirrored. This separates summary-flag errors from mirror-placement errors. A case that sets every source and every enable checks that all 21 low bits are set and that the upper bits stay clear. The mask registers are given overlapping set and clear patterns, and patterns with zero bits, to show that writes accumulate instead of overwriting. The routing tests select a local source, then a bank source, then an out-of-range number. Combined with a second active source, these show whether a routed source is removed from the normal request or duplicated into it.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  // Group sizes fixed by the pending word layout
  localparam int unsigned LOCAL_N = 8;
  localparam int unsigned BANK_N  = 32;
  localparam int unsigned TOTAL_N = LOCAL_N + 2 * BANK_N;

  // Byte offsets
  localparam logic [5:0] OFS_PEND_LOCAL = 6'h00;
  localparam logic [5:0] OFS_PEND_A     = 6'h04;
  localparam logic [5:0] OFS_PEND_B     = 6'h08;
  localparam logic [5:0] OFS_FAST_CTRL  = 6'h0C;
  localparam logic [5:0] OFS_SET_A      = 6'h10;
  localparam logic [5:0] OFS_SET_B      = 6'h14;
  localparam logic [5:0] OFS_SET_LOCAL  = 6'h18;
  localparam logic [5:0] OFS_CLR_A      = 6'h1C;
  localparam logic [5:0] OFS_CLR_B      = 6'h20;
  localparam logic [5:0] OFS_CLR_LOCAL  = 6'h24;

  // Bank bits mirrored into the local pending word, in bit order
  localparam int unsigned MIRROR_A_N = 5;
  localparam int unsigned MIRROR_B_N = 6;
  localparam int unsigned MIRROR_A [MIRROR_A_N] = '{7, 9, 10, 18, 19};
  localparam int unsigned MIRROR_B [MIRROR_B_N] = '{21, 22, 23, 24, 25, 30};

  // Group index for mask strobes
  typedef enum logic [1:0] {
    GRP_LOCAL = 2'd0,
    GRP_A     = 2'd1,
    GRP_B     = 2'd2
  } grp_e;
endpackage

// File: rtl/irqb_enable_reg.sv
module irqb_enable_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (set_we) begin
      mask_q <= mask_q | bits;
    end else if (clr_we) begin
      mask_q <= mask_q & ~bits;
    end
  end
endmodule

// File: rtl/irqb_status.sv
module irqb_status
  import irqb_pkg::*;
#(
  parameter int unsigned NL = LOCAL_N,
  parameter int unsigned NB = BANK_N,
  parameter int unsigned DW = 32,
  localparam int unsigned NT = NL + 2 * NB
) (
  input  logic [NL-1:0] src_l,
  input  logic [NB-1:0] src_a,
  input  logic [NB-1:0] src_b,
  input  logic [NL-1:0] en_l,
  input  logic [NB-1:0] en_a,
  input  logic [NB-1:0] en_b,
  output logic [DW-1:0] word_local,
  output logic [DW-1:0] word_a,
  output logic [DW-1:0] word_b,
  output logic [NT-1:0] flat
);
  localparam int unsigned SUM_A = NL;
  localparam int unsigned SUM_B = NL + 1;
  localparam int unsigned MA0   = NL + 2;
  localparam int unsigned MB0   = MA0 + MIRROR_A_N;

  logic [NL-1:0] pend_l;
  logic [NB-1:0] pend_a;
  logic [NB-1:0] pend_b;
  logic [MIRROR_A_N-1:0] mir_a;
  logic [MIRROR_B_N-1:0] mir_b;

  assign pend_l = src_l & en_l;
  assign pend_a = src_a & en_a;
  assign pend_b = src_b & en_b;

  for (genvar k = 0; k < MIRROR_A_N; k++) begin : g_mir_a
    assign mir_a[k] = pend_a[MIRROR_A[k]];
  end
  for (genvar k = 0; k < MIRROR_B_N; k++) begin : g_mir_b
    assign mir_b[k] = pend_b[MIRROR_B[k]];
  end

  always_comb begin
    word_local = '0;
    word_local[NL-1:0] = pend_l;
    word_local[SUM_A] = |pend_a;
    word_local[SUM_B] = |pend_b;
    word_local[MA0 +: MIRROR_A_N] = mir_a;
    word_local[MB0 +: MIRROR_B_N] = mir_b;
  end

  assign word_a = DW'(pend_a);
  assign word_b = DW'(pend_b);
  assign flat   = {pend_b, pend_a, pend_l};
endmodule

// File: rtl/irqb_route.sv
module irqb_route #(
  parameter int unsigned NT = 72,
  localparam int unsigned SW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] flat,
  input  logic          fast_en,
  input  logic [SW-1:0] fast_sel,
  output logic          irq_o,
  output logic          fiq_o
);
  logic [NT-1:0] route;

  for (genvar i = 0; i < NT; i++) begin : g_route
    assign route[i] = fast_en && (fast_sel == SW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |(flat & ~route);
      fiq_o <= |(flat & route);
    end
  end
endmodule

// File: rtl/irqb_regs.sv
module irqb_regs
  import irqb_pkg::*;
#(
  parameter int unsigned NL = LOCAL_N,
  parameter int unsigned NB = BANK_N,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6,
  parameter int unsigned SW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [SW:0]   wctl,
  input  logic [DW-1:0] word_local,
  input  logic [DW-1:0] word_a,
  input  logic [DW-1:0] word_b,
  input  logic [NL-1:0] en_l,
  input  logic [NB-1:0] en_a,
  input  logic [NB-1:0] en_b,
  output logic [2:0]    set_we,
  output logic [2:0]    clr_we,
  output logic          fast_en,
  output logic [SW-1:0] fast_sel,
  output logic [DW-1:0] rdata
);
  logic [SW:0]   ctrl_q;
  logic [DW-1:0] rd_mux;

  function automatic logic hit(input logic [AW-1:0] a, input logic [5:0] ofs);
    return a == AW'(ofs);
  endfunction

  always_comb begin
    set_we = '0;
    clr_we = '0;
    if (wr_en) begin
      set_we[GRP_LOCAL] = hit(addr, OFS_SET_LOCAL);
      set_we[GRP_A]     = hit(addr, OFS_SET_A);
      set_we[GRP_B]     = hit(addr, OFS_SET_B);
      clr_we[GRP_LOCAL] = hit(addr, OFS_CLR_LOCAL);
      clr_we[GRP_A]     = hit(addr, OFS_CLR_A);
      clr_we[GRP_B]     = hit(addr, OFS_CLR_B);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && hit(addr, OFS_FAST_CTRL)) begin
      ctrl_q <= wctl;
    end
  end

  assign fast_en  = ctrl_q[SW];
  assign fast_sel = ctrl_q[SW-1:0];

  always_comb begin
    rd_mux = '0;
    if (hit(addr, OFS_PEND_LOCAL)) begin
      rd_mux = word_local;
    end else if (hit(addr, OFS_PEND_A)) begin
      rd_mux = word_a;
    end else if (hit(addr, OFS_PEND_B)) begin
      rd_mux = word_b;
    end else if (hit(addr, OFS_FAST_CTRL)) begin
      rd_mux = DW'(ctrl_q);
    end else if (hit(addr, OFS_SET_A) || hit(addr, OFS_CLR_A)) begin
      rd_mux = DW'(en_a);
    end else if (hit(addr, OFS_SET_B) || hit(addr, OFS_CLR_B)) begin
      rd_mux = DW'(en_b);
    end else if (hit(addr, OFS_SET_LOCAL) || hit(addr, OFS_CLR_LOCAL)) begin
      rd_mux = DW'(en_l);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqb_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6,
  localparam int unsigned NL = LOCAL_N,
  localparam int unsigned NB = BANK_N,
  localparam int unsigned NT = NL + 2 * NB,
  localparam int unsigned SW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NL-1:0] src_local,
  input  logic [NB-1:0] src_bank_a,
  input  logic [NB-1:0] src_bank_b,
  output logic          irq_o,
  output logic          fiq_o
);
  logic [NL-1:0] en_l_q;
  logic [NB-1:0] en_a_q;
  logic [NB-1:0] en_b_q;
  logic [2:0]    set_we;
  logic [2:0]    clr_we;
  logic          fast_en;
  logic [SW-1:0] fast_sel;
  logic [DW-1:0] word_local;
  logic [DW-1:0] word_a;
  logic [DW-1:0] word_b;
  logic [NT-1:0] flat_pend;

  irqb_enable_reg #(.W(NL)) u_en_local (
    .clk(clk), .rst(rst),
    .set_we(set_we[GRP_LOCAL]), .clr_we(clr_we[GRP_LOCAL]),
    .bits(wdata[NL-1:0]), .mask_q(en_l_q)
  );
  irqb_enable_reg #(.W(NB)) u_en_a (
    .clk(clk), .rst(rst),
    .set_we(set_we[GRP_A]), .clr_we(clr_we[GRP_A]),
    .bits(wdata[NB-1:0]), .mask_q(en_a_q)
  );
  irqb_enable_reg #(.W(NB)) u_en_b (
    .clk(clk), .rst(rst),
    .set_we(set_we[GRP_B]), .clr_we(clr_we[GRP_B]),
    .bits(wdata[NB-1:0]), .mask_q(en_b_q)
  );

  irqb_status #(.NL(NL), .NB(NB), .DW(DW)) u_status (
    .src_l(src_local), .src_a(src_bank_a), .src_b(src_bank_b),
    .en_l(en_l_q), .en_a(en_a_q), .en_b(en_b_q),
    .word_local(word_local), .word_a(word_a), .word_b(word_b),
    .flat(flat_pend)
  );

  irqb_regs #(.NL(NL), .NB(NB), .DW(DW), .AW(AW), .SW(SW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wctl(wdata[SW:0]),
    .word_local(word_local), .word_a(word_a), .word_b(word_b),
    .en_l(en_l_q), .en_a(en_a_q), .en_b(en_b_q),
    .set_we(set_we), .clr_we(clr_we),
    .fast_en(fast_en), .fast_sel(fast_sel), .rdata(rdata)
  );

  irqb_route #(.NT(NT)) u_route (
    .clk(clk), .rst(rst), .flat(flat_pend),
    .fast_en(fast_en), .fast_sel(fast_sel),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 32,
  parameter int unsigned NT = 72,
  parameter int unsigned SW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq_o,
  input logic          fiq_o,
  input logic [NB-1:0] en_a,
  input logic          fast_en,
  input logic [SW-1:0] fast_sel,
  input logic [NT-1:0] flat_pend
);
  // R1: outputs quiet the cycle after reset is seen
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o && rdata == '0));

  // R2: set write leaves every written one in the bank A mask
  p_set_sticks_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(6'h10)) |=>
      ((en_a & $past(wdata[NB-1:0])) == $past(wdata[NB-1:0])));

  // R3: clear write removes every written one from the bank A mask
  p_clear_takes_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(6'h1C)) |=> ((en_a & $past(wdata[NB-1:0])) == '0));

  // R8: nothing pending means no normal request next cycle
  p_irq_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (flat_pend == '0) |=> !irq_o);

  // R9: fast request only while routing was enabled
  p_fiq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(fast_en));

  // R10: fast request only for a selection in range
  p_fiq_valid_sel_r10: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> (32'($past(fast_sel)) < NT));

  // R11: read data is zero after a cycle without a read
  p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

bind irq_bank_ctrl irqb_checker #(
  .DW(DW), .AW(AW), .NB(NB), .NT(NT), .SW(SW)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o),
  .en_a(en_a_q), .fast_en(fast_en), .fast_sel(fast_sel),
  .flat_pend(flat_pend)
);

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  src_local = '0;
  logic [31:0] src_bank_a = '0;
  logic [31:0] src_bank_b = '0;
  logic        irq_o;
  logic        fiq_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_bank_ctrl u_irq_bank_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_local(src_local),
    .src_bank_a(src_bank_a), .src_bank_b(src_bank_b),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // Let source changes propagate into the registered outputs
  task automatic settle();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic clear_all();
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h0C, 32'h0);
    src_local = '0; src_bank_a = '0; src_bank_b = '0;
  endtask

  task automatic t_reset();
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 fiq", {31'b0, fiq_o}, 32'h0);
    for (int a = 0; a <= 'h24; a += 4) rd_check("R1 regs", 6'(a), 32'h0);
  endtask

  task automatic t_set();
    wr(6'h10, 32'h0000_00F0);
    wr(6'h10, 32'h0000_000F);
    rd_check("R2 accumulate A", 6'h10, 32'h0000_00FF);
    wr(6'h18, 32'hFFFF_FFFF);
    rd_check("R2 local width", 6'h18, 32'h0000_00FF);
    wr(6'h14, 32'h8000_0001);
    rd_check("R3 clear addr reads mask", 6'h20, 32'h8000_0001);
    rd_check("R3 clear addr reads mask A", 6'h1C, 32'h0000_00FF);
  endtask

  task automatic t_clear();
    wr(6'h1C, 32'h0000_000F);
    rd_check("R3 clear A", 6'h10, 32'h0000_00F0);
    wr(6'h24, 32'h0000_0001);
    rd_check("R3 clear local", 6'h24, 32'h0000_00FE);
    wr(6'h20, 32'h0);
    rd_check("R3 zero clear no effect", 6'h14, 32'h8000_0001);
    clear_all();
    rd_check("R3 all cleared", 6'h10, 32'h0);
  endtask

  task automatic t_bank_pending();
    clear_all();
    wr(6'h10, 32'h0000_FFFF);
    wr(6'h14, 32'hFFFF_0000);
    src_bank_a = 32'hA5A5_0F0F;
    src_bank_b = 32'h1234_5678;
    rd_check("R4 bank A", 6'h04, 32'h0000_0F0F);
    rd_check("R4 bank B", 6'h08, 32'h1234_0000);
  endtask

  task automatic t_local_pending();
    clear_all();
    wr(6'h18, 32'h0000_000F);
    src_local = 8'h3C;
    rd_check("R5 local masked", 6'h00, 32'h0000_000C);
  endtask

  task automatic t_summary();
    clear_all();
    wr(6'h10, 32'h0000_0008);
    src_bank_a = 32'h0000_0008;
    rd_check("R6 summary A", 6'h00, 32'h0000_0100);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h10, 32'h0000_0080);
    src_bank_a = 32'h0000_0080;
    rd_check("R6 summary with mirror", 6'h00, 32'h0000_0500);
    wr(6'h14, 32'h4000_0000);
    src_bank_b = 32'h4000_0000;
    rd_check("R6 summary B", 6'h00, 32'h0010_0700);
  endtask

  task automatic t_mirrors();
    clear_all();
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    src_bank_a = 32'h0004_0000;
    rd_check("R7 A18", 6'h00, 32'h0000_2100);
    src_bank_a = 32'h0008_0000;
    rd_check("R7 A19", 6'h00, 32'h0000_4100);
    src_bank_a = '0;
    src_bank_b = 32'h0020_0000;
    rd_check("R7 B21", 6'h00, 32'h0000_8200);
    src_bank_b = 32'h0200_0000;
    rd_check("R7 B25", 6'h00, 32'h0008_0200);
    src_bank_b = 32'h0400_0000;
    rd_check("R7 B26 unmirrored", 6'h00, 32'h0000_0200);
    wr(6'h18, 32'hFF);
    src_local = 8'hFF; src_bank_a = '1; src_bank_b = '1;
    rd_check("R5 R7 all set", 6'h00, 32'h001F_FFFF);
  endtask

  task automatic t_irq();
    clear_all();
    settle();
    check("R8 idle", {31'b0, irq_o}, 32'h0);
    src_bank_b = 32'h0000_0020;
    settle();
    check("R8 masked source", {31'b0, irq_o}, 32'h0);
    wr(6'h14, 32'h0000_0020);
    @(posedge clk); #1;
    check("R8 enabled source", {31'b0, irq_o}, 32'h1);
    rd_check("R8 read once", 6'h08, 32'h0000_0020);
    rd_check("R8 read again", 6'h08, 32'h0000_0020);
    check("R8 still high", {31'b0, irq_o}, 32'h1);
    src_bank_b = '0;
    settle();
    check("R8 dropped", {31'b0, irq_o}, 32'h0);
    wr(6'h18, 32'h1);
    src_local = 8'h01;
    settle();
    check("R8 local", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_fiq();
    clear_all();
    wr(6'h18, 32'h04);
    src_local = 8'h04;
    wr(6'h0C, 32'hFFFF_FF82);
    rd_check("R9 ctrl readback", 6'h0C, 32'h0000_0082);
    settle();
    check("R9 fiq local", {31'b0, fiq_o}, 32'h1);
    check("R9 irq removed", {31'b0, irq_o}, 32'h0);
    wr(6'h10, 32'h10);
    src_bank_a = 32'h10;
    settle();
    check("R9 irq other", {31'b0, irq_o}, 32'h1);
    wr(6'h0C, 32'h8C);
    settle();
    check("R9 fiq bank A12", {31'b0, fiq_o}, 32'h1);
    src_local = '0;
    settle();
    check("R9 irq without local", {31'b0, irq_o}, 32'h0);
    wr(6'h0C, 32'h0C);
    settle();
    check("R9 fiq off", {31'b0, fiq_o}, 32'h0);
    check("R9 back to irq", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_fiq_invalid();
    clear_all();
    wr(6'h14, 32'h8000_0000);
    src_bank_b = 32'h8000_0000;
    wr(6'h0C, 32'hC8);
    settle();
    check("R10 fiq low", {31'b0, fiq_o}, 32'h0);
    check("R10 irq kept", {31'b0, irq_o}, 32'h1);
    wr(6'h0C, 32'hC7);
    settle();
    check("R10 sel71 fiq", {31'b0, fiq_o}, 32'h1);
    check("R10 sel71 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_unmapped();
    clear_all();
    wr(6'h10, 32'h0000_00AA);
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h11, 32'hFFFF_FFFF);
    rd_check("R11 mask unchanged", 6'h10, 32'h0000_00AA);
    rd_check("R11 unmapped", 6'h28, 32'h0);
    rd_check("R11 misaligned", 6'h11, 32'h0);
    @(posedge clk); #1;
    check("R11 idle rdata", rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_set();
    t_clear();
    t_bank_pending();
    t_local_pending();
    t_summary();
    t_mirrors();
    t_irq();
    t_fiq();
    t_fiq_invalid();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule